// File: doc/BRIEF.md
# Digital Gain-Control Loop with Pseudo-Float Gain

This block keeps a complex baseband stream at a chosen level. Each cycle it may receive a magnitude estimate of the signal. It subtracts a programmed target level from that estimate. The difference is scaled by a loop gain that has a small mantissa and a shift exponent. The result is integrated in an accumulator that stays between programmed limits. The upper eight accumulator bits form the gain word. That word is read as a 2-bit exponent and a 6-bit mantissa. The gain it encodes multiplies both the in-phase and the quadrature sample before they leave the block.

A second, independent comparator drives an active-low flag whenever a magnitude exceeds a power threshold. The current gain word is presented on an output so control software can read it. When the magnitude comes from a decimated path that alternates mid-symbol and end-of-symbol values, only the end-of-symbol values steer the loop. The magnitude computation lies upstream and is not part of this block.

Top module: `agc_loop`

## Requirements
- R1: The accumulator is 20 bits wide, unsigned, with 12 fraction bits, and resets to zero. On an accepted magnitude, err = mag_in − target_lvl. Both are 8-bit unsigned values with 7 fraction bits. The step is delta = floor(err·lg_mant / 2^lg_exp), with lg_mant 4 bits and lg_exp 3 bits. The new accumulator value is clamp(acc − delta), and it appears on gain_word = acc[19:12] one clock after the accepted magnitude. Without mag_valid the accumulator does not change.
- R2: While agc_hold is 1, the accumulator and gain_word do not change, whatever the magnitudes are.
- R3: With dec_path = 1, only magnitudes with mag_end = 1 are accepted. A magnitude with mag_end = 0 leaves gain_word unchanged. With dec_path = 0, mag_end is ignored.
- R4: The clamp bounds are the upper bound {lim_hi, 12'hFFF} and the lower bound {lim_lo, 12'h000}. A result above the upper bound becomes the upper bound. Otherwise, a result below the lower bound becomes the lower bound.
- R5: When lim_lo equals lim_hi, the first accepted magnitude sets gain_word to that value. Later magnitudes do not move it.
- R6: gain_word bits [7:6] are the exponent e and bits [5:0] are the mantissa m. Each output sample is round((x·(64+m)·2^e)/64), rounding half toward +∞. It is computed with the gain word that holds in the cycle the sample is taken.
- R7: Outputs beyond the signed 8-bit range saturate to +127 or −128.
- R8: On each mag_valid, thresh_n is registered as 0 if mag_in > pwr_thr and as 1 otherwise, including when the two are equal. It holds between magnitudes and is independent of agc_hold and mag_end.
- R9: iq_out_valid follows iq_valid one clock later.
- R10: After reset, gain_word is 0, thresh_n is 1, iq_out_valid is 0, and i_out and q_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mag_valid | input | 1 | Magnitude strobe |
| mag_in | input | 8 | Magnitude estimate, unsigned, 1.7 format |
| mag_end | input | 1 | Marks an end-of-symbol magnitude |
| dec_path | input | 1 | Magnitude source is the decimated path |
| agc_hold | input | 1 | Zero the error and freeze the gain |
| target_lvl | input | 8 | Target magnitude, 1.7 format |
| pwr_thr | input | 8 | Power threshold, 1.7 format |
| lg_mant | input | 4 | Loop gain mantissa (M/16) |
| lg_exp | input | 3 | Loop gain exponent (extra right shift) |
| lim_lo | input | 8 | Lower gain limit, gain-word format |
| lim_hi | input | 8 | Upper gain limit, gain-word format |
| iq_valid | input | 1 | Sample strobe |
| i_in | input | 8 | In-phase sample, signed |
| q_in | input | 8 | Quadrature sample, signed |
| iq_out_valid | output | 1 | Output sample strobe |
| i_out | output | 8 | Scaled in-phase sample |
| q_out | output | 8 | Scaled quadrature sample |
| gain_word | output | 8 | Current gain word {e, m} |
| thresh_n | output | 1 | Low while last magnitude exceeded pwr_thr |

## Verification
The hardest state to reach from the ports is the hidden 12-bit fraction of the accumulator. Only its carries into gain_word can be seen. The bench therefore tracks the full 20-bit value in its own model and compares gain_word after every step. This covers long runs with small negative errors and floor-rounded shifts. The upper clamp needs dozens of maximum-mantissa steps with zero magnitude before it takes effect. The gain-apply path needs specific gain words. Programming equal limits places gain_word at any chosen value in one step, so the rounding and saturation cases can be driven at unity, 1.5×, 2× and maximum gain.

// File: rtl/agc_pkg.sv
package agc_pkg;

    // gain word layout: {exponent, mantissa}
    localparam int GEXP_W  = 2;
    localparam int GMANT_W = 6;
    localparam int GW_W    = GEXP_W + GMANT_W;

    // loop gain field widths
    localparam int LMANT_W = 4;
    localparam int LEXP_W  = 3;

    typedef struct packed {
        logic [GEXP_W-1:0]  ex;
        logic [GMANT_W-1:0] mant;
    } gain_word_t;

    typedef struct packed {
        logic [LMANT_W-1:0] mant;
        logic [LEXP_W-1:0]  ex;
    } loop_gain_t;

    typedef struct packed {
        logic       upd;
        logic [GW_W-1:0] lo;
        logic [GW_W-1:0] hi;
    } clamp_cfg_t;

    // linear multiplier 1.m scaled by 2^GMANT_W
    function automatic logic [GMANT_W:0] unity_mant(input logic [GMANT_W-1:0] m);
        return {1'b1, m};
    endfunction

endpackage

// File: rtl/agc_err_scale.sv
module agc_err_scale
    import agc_pkg::*;
#(
    parameter int MAG_W   = 8,
    parameter int DELTA_W = MAG_W + LMANT_W + 2
) (
    input  logic [MAG_W-1:0]        mag,
    input  logic [MAG_W-1:0]        target,
    input  loop_gain_t              lgain,
    output logic signed [DELTA_W-1:0] delta
);
    logic signed [MAG_W:0]        err;
    logic signed [DELTA_W-1:0]    err_x;
    logic signed [DELTA_W-1:0]    mant_x;
    logic signed [DELTA_W-1:0]    prod;

    always_comb begin
        err    = $signed({1'b0, mag}) - $signed({1'b0, target});
        err_x  = {{(DELTA_W-MAG_W-1){err[MAG_W]}}, err};
        mant_x = $signed({{(DELTA_W-LMANT_W){1'b0}}, lgain.mant});
        prod   = err_x * mant_x;
        delta  = prod >>> lgain.ex;
    end
endmodule

// File: rtl/agc_integrator.sv
module agc_integrator
    import agc_pkg::*;
#(
    parameter int FRAC_W  = 12,
    parameter int DELTA_W = 14
) (
    input  logic                      clk,
    input  logic                      rst,
    input  clamp_cfg_t                cfg,
    input  logic signed [DELTA_W-1:0] delta,
    output gain_word_t                gword
);
    localparam int ACC_W = GW_W + FRAC_W;
    localparam int SUM_W = ACC_W + 2;

    logic [ACC_W-1:0]        acc_q;
    logic signed [SUM_W-1:0] sum;
    logic signed [SUM_W-1:0] delta_x;
    logic signed [SUM_W-1:0] bound_hi;
    logic signed [SUM_W-1:0] bound_lo;
    logic [ACC_W-1:0]        acc_d;

    always_comb begin
        delta_x  = {{(SUM_W-DELTA_W){delta[DELTA_W-1]}}, delta};
        sum      = $signed({2'b00, acc_q}) - delta_x;
        bound_hi = $signed({2'b00, cfg.hi, {FRAC_W{1'b1}}});
        bound_lo = $signed({2'b00, cfg.lo, {FRAC_W{1'b0}}});
        if (sum > bound_hi)
            acc_d = bound_hi[ACC_W-1:0];
        else if (sum < bound_lo)
            acc_d = bound_lo[ACC_W-1:0];
        else
            acc_d = sum[ACC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (cfg.upd)
            acc_q <= acc_d;
    end

    assign gword = gain_word_t'(acc_q[ACC_W-1 -: GW_W]);
endmodule

// File: rtl/agc_gain_apply.sv
module agc_gain_apply
    import agc_pkg::*;
#(
    parameter int IQ_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    input  gain_word_t             gword,
    input  logic signed [IQ_W-1:0] x,
    output logic signed [IQ_W-1:0] y
);
    localparam int PW = IQ_W + GMANT_W + 2 + (1 << GEXP_W) - 1 + 1;
    localparam logic signed [PW-1:0] HALF = PW'(1 << (GMANT_W - 1));
    localparam logic signed [PW-1:0] MAXV = PW'((1 << (IQ_W - 1)) - 1);
    localparam logic signed [PW-1:0] MINV = -(PW'(1 << (IQ_W - 1)));

    logic signed [PW-1:0] x_x;
    logic signed [PW-1:0] g_x;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] shifted;
    logic signed [PW-1:0] scaled;
    logic signed [IQ_W-1:0] sat;

    always_comb begin
        x_x     = {{(PW-IQ_W){x[IQ_W-1]}}, x};
        g_x     = $signed({{(PW-GMANT_W-1){1'b0}}, unity_mant(gword.mant)});
        prod    = x_x * g_x;
        shifted = prod <<< gword.ex;
        scaled  = (shifted + HALF) >>> GMANT_W;
        if (scaled > MAXV)
            sat = MAXV[IQ_W-1:0];
        else if (scaled < MINV)
            sat = MINV[IQ_W-1:0];
        else
            sat = scaled[IQ_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            y <= '0;
        else if (en)
            y <= sat;
    end
endmodule

// File: rtl/agc_level_det.sv
module agc_level_det #(
    parameter int MAG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic [MAG_W-1:0] mag,
    input  logic [MAG_W-1:0] limit,
    output logic             over_n
);
    always_ff @(posedge clk) begin
        if (rst)
            over_n <= 1'b1;
        else if (strobe)
            over_n <= !(mag > limit);
    end
endmodule

// File: rtl/agc_loop.sv
module agc_loop
    import agc_pkg::*;
#(
    parameter int MAG_W  = 8,
    parameter int IQ_W   = 8,
    parameter int FRAC_W = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   mag_valid,
    input  logic [MAG_W-1:0]       mag_in,
    input  logic                   mag_end,
    input  logic                   dec_path,
    input  logic                   agc_hold,
    input  logic [MAG_W-1:0]       target_lvl,
    input  logic [MAG_W-1:0]       pwr_thr,
    input  logic [LMANT_W-1:0]     lg_mant,
    input  logic [LEXP_W-1:0]      lg_exp,
    input  logic [GW_W-1:0]        lim_lo,
    input  logic [GW_W-1:0]        lim_hi,
    input  logic                   iq_valid,
    input  logic signed [IQ_W-1:0] i_in,
    input  logic signed [IQ_W-1:0] q_in,
    output logic                   iq_out_valid,
    output logic signed [IQ_W-1:0] i_out,
    output logic signed [IQ_W-1:0] q_out,
    output logic [GW_W-1:0]        gain_word,
    output logic                   thresh_n
);
    localparam int DELTA_W = MAG_W + LMANT_W + 2;
    localparam int NCH     = 2;

    logic                      take;
    loop_gain_t                lgain;
    clamp_cfg_t                ccfg;
    logic signed [DELTA_W-1:0] delta;
    gain_word_t                gword;
    logic signed [IQ_W-1:0]    ch_in  [NCH];
    logic signed [IQ_W-1:0]    ch_out [NCH];

    // magnitudes steer the loop only when not held and, on the
    // decimated path, only at end of symbol
    assign take  = mag_valid && !agc_hold && (!dec_path || mag_end);
    assign lgain = '{mant: lg_mant, ex: lg_exp};
    assign ccfg  = '{upd: take, lo: lim_lo, hi: lim_hi};

    agc_err_scale #(.MAG_W(MAG_W), .DELTA_W(DELTA_W)) err_i (
        .mag    (mag_in),
        .target (target_lvl),
        .lgain  (lgain),
        .delta  (delta)
    );

    agc_integrator #(.FRAC_W(FRAC_W), .DELTA_W(DELTA_W)) int_i (
        .clk   (clk),
        .rst   (rst),
        .cfg   (ccfg),
        .delta (delta),
        .gword (gword)
    );

    agc_level_det #(.MAG_W(MAG_W)) lvl_i (
        .clk    (clk),
        .rst    (rst),
        .strobe (mag_valid),
        .mag    (mag_in),
        .limit  (pwr_thr),
        .over_n (thresh_n)
    );

    assign ch_in[0] = i_in;
    assign ch_in[1] = q_in;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        agc_gain_apply #(.IQ_W(IQ_W)) mul_i (
            .clk   (clk),
            .rst   (rst),
            .en    (iq_valid),
            .gword (gword),
            .x     (ch_in[c]),
            .y     (ch_out[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            iq_out_valid <= 1'b0;
        else
            iq_out_valid <= iq_valid;
    end

    assign i_out     = ch_out[0];
    assign q_out     = ch_out[1];
    assign gain_word = gword;
endmodule

// File: rtl/agc_loop_chk.sv
module agc_loop_chk #(
    parameter int MAG_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             mag_valid,
    input logic             mag_end,
    input logic             dec_path,
    input logic             agc_hold,
    input logic [MAG_W-1:0] mag_in,
    input logic [MAG_W-1:0] pwr_thr,
    input logic [7:0]       lim_lo,
    input logic [7:0]       lim_hi,
    input logic             iq_valid,
    input logic             iq_out_valid,
    input logic [7:0]       gain_word,
    input logic             thresh_n
);
    logic acc_ok;
    assign acc_ok = mag_valid && !agc_hold && (!dec_path || mag_end);

    // R1
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !mag_valid |=> $stable(gain_word));

    // R2
    hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        agc_hold |=> $stable(gain_word));

    // R3
    mid_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (mag_valid && dec_path && !mag_end) |=> $stable(gain_word));

    // R4
    clamp_range_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_ok && lim_lo <= lim_hi) |=>
            (gain_word >= $past(lim_lo) && gain_word <= $past(lim_hi)));

    // R5
    fixed_gain_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_ok && lim_lo == lim_hi) |=> gain_word == $past(lim_lo));

    // R8
    thresh_low_chk: assert property (@(posedge clk) disable iff (rst)
        (mag_valid && mag_in > pwr_thr) |=> !thresh_n);

    // R8
    thresh_high_chk: assert property (@(posedge clk) disable iff (rst)
        (mag_valid && mag_in <= pwr_thr) |=> thresh_n);

    // R9
    out_valid_chk: assert property (@(posedge clk) disable iff (rst)
        iq_valid |=> iq_out_valid);

    // R9
    out_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !iq_valid |=> !iq_out_valid);
endmodule

bind agc_loop agc_loop_chk #(.MAG_W(MAG_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .mag_valid    (mag_valid),
    .mag_end      (mag_end),
    .dec_path     (dec_path),
    .agc_hold     (agc_hold),
    .mag_in       (mag_in),
    .pwr_thr      (pwr_thr),
    .lim_lo       (lim_lo),
    .lim_hi       (lim_hi),
    .iq_valid     (iq_valid),
    .iq_out_valid (iq_out_valid),
    .gain_word    (gain_word),
    .thresh_n     (thresh_n)
);

// File: tb/agc_loop_tb_top.sv
module agc_loop_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mag_valid = 0, mag_end = 0, dec_path = 0, agc_hold = 0;
    logic [7:0] mag_in = 0, target_lvl = 0, pwr_thr = 0;
    logic [3:0] lg_mant = 0;
    logic [2:0] lg_exp = 0;
    logic [7:0] lim_lo = 0, lim_hi = 8'hFF;
    logic iq_valid = 0;
    logic signed [7:0] i_in = 0, q_in = 0;
    logic iq_out_valid;
    logic signed [7:0] i_out, q_out;
    logic [7:0] gain_word;
    logic thresh_n;

    int tests = 0;
    int fails = 0;
    int acc_m = 0;
    logic signed [7:0] exp_i_q[$];
    logic signed [7:0] exp_q_q[$];

    always #10 clk = ~clk;

    agc_loop dut_i (
        .clk(clk), .rst(rst), .mag_valid(mag_valid), .mag_in(mag_in),
        .mag_end(mag_end), .dec_path(dec_path), .agc_hold(agc_hold),
        .target_lvl(target_lvl), .pwr_thr(pwr_thr), .lg_mant(lg_mant),
        .lg_exp(lg_exp), .lim_lo(lim_lo), .lim_hi(lim_hi),
        .iq_valid(iq_valid), .i_in(i_in), .q_in(q_in),
        .iq_out_valid(iq_out_valid), .i_out(i_out), .q_out(q_out),
        .gain_word(gain_word), .thresh_n(thresh_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic mag_step(input int mag, input bit endf, input string tag);
        int err, d, n, up, lo, th;
        mag_in = 8'(mag); mag_end = endf; mag_valid = 1'b1;
        if (!agc_hold && (!dec_path || endf)) begin
            err = mag - int'(target_lvl);
            d = (err * int'(lg_mant)) >>> int'(lg_exp);
            n = acc_m - d;
            up = int'(lim_hi) * 4096 + 4095;
            lo = int'(lim_lo) * 4096;
            if (n > up) n = up;
            else if (n < lo) n = lo;
            acc_m = n;
        end
        th = (mag > int'(pwr_thr)) ? 0 : 1;
        @(posedge clk); @(negedge clk);
        mag_valid = 1'b0;
        check(int'(gain_word) == (acc_m >> 12), tag, int'(gain_word), acc_m >> 12);
        check(int'(thresh_n) == th, "R8 thresh", int'(thresh_n), th);
    endtask

    function automatic logic signed [7:0] model_mul(input int x);
        int g, e, m, v, r;
        g = acc_m >> 12;
        e = g >> 6; m = g & 63;
        v = x * (64 + m) * (1 << e);
        r = (v + 32) >>> 6;
        if (r > 127) r = 127;
        if (r < -128) r = -128;
        return 8'(r);
    endfunction

    task automatic iq_send(input int xi, input int xq);
        exp_i_q.push_back(model_mul(xi));
        exp_q_q.push_back(model_mul(xq));
        i_in = 8'(xi); q_in = 8'(xq); iq_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        iq_valid = 1'b0;
    endtask

    task automatic set_fixed(input int g);
        lim_lo = 8'(g); lim_hi = 8'(g);
        mag_step(0, 1'b1, "R5 fixed gain");
    endtask

    // monitor: compares scaled samples against the expected queue
    always @(negedge clk) begin
        if (!rst && iq_out_valid) begin
            logic signed [7:0] ei, eq;
            if (exp_i_q.size() == 0) begin
                check(1'b0, "R9 unexpected output", 1, 0);
            end else begin
                ei = exp_i_q.pop_front();
                eq = exp_q_q.pop_front();
                check(i_out == ei, "R6/R7 i_out", int'(i_out), int'(ei));
                check(q_out == eq, "R6/R7 q_out", int'(q_out), int'(eq));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(gain_word == 0, "R10 gain_word", int'(gain_word), 0);
        check(thresh_n == 1, "R10 thresh_n", int'(thresh_n), 1);
        check(iq_out_valid == 0, "R10 valid", int'(iq_out_valid), 0);
        check(i_out == 0 && q_out == 0, "R10 iq", int'(i_out), 0);

        // R1 integrate upward with small magnitude
        target_lvl = 8'h40; pwr_thr = 8'h80; lg_mant = 4'd8; lg_exp = 3'd0;
        lim_lo = 8'h00; lim_hi = 8'hFF;
        for (int k = 0; k < 40; k++) mag_step(0, 1'b0, "R1 rise");
        repeat (2) @(negedge clk);
        check(int'(gain_word) == (acc_m >> 12), "R1 idle", int'(gain_word), acc_m >> 12);

        // R4 lower clamp with large magnitude, R8 flag low
        for (int k = 0; k < 30; k++) mag_step(8'hFF, 1'b0, "R4 lower clamp");
        check(gain_word == 0, "R4 at lower", int'(gain_word), 0);
        mag_step(8'h80, 1'b0, "R8 equal");
        mag_step(8'h81, 1'b0, "R8 exceed");

        // R4 upper clamp
        lim_hi = 8'h10; lg_mant = 4'd15;
        for (int k = 0; k < 100; k++) mag_step(0, 1'b0, "R4 upper clamp");
        check(gain_word == 8'h10, "R4 at upper", int'(gain_word), 16);

        // R1 floor shift with large exponent
        lim_hi = 8'hFF; lg_exp = 3'd3;
        for (int k = 0; k < 20; k++) mag_step(8'h3F, 1'b0, "R1 neg shift");
        for (int k = 0; k < 20; k++) mag_step(8'h41, 1'b0, "R1 pos shift");

        // R2 hold
        lg_exp = 3'd0; agc_hold = 1'b1;
        for (int k = 0; k < 10; k++) mag_step(8'hFF, 1'b0, "R2 hold");
        agc_hold = 1'b0;

        // R3 decimated path
        dec_path = 1'b1;
        for (int k = 0; k < 10; k++) mag_step(8'hFF, 1'b0, "R3 mid ignored");
        for (int k = 0; k < 5; k++) mag_step(8'hFF, 1'b1, "R3 end used");
        dec_path = 1'b0;
        mag_step(0, 1'b0, "R3 end ignored when not decimated");

        // R5 fixed gain stays put
        set_fixed(8'h9A);
        for (int k = 0; k < 5; k++) mag_step(8'hFF, 1'b0, "R5 stays");

        // R6/R7 gain application at several gain words
        set_fixed(8'h00);
        iq_send(1, -1); iq_send(127, -128); iq_send(37, -5);
        set_fixed(8'h20);
        iq_send(1, -1); iq_send(3, -3); iq_send(100, -100);
        set_fixed(8'h40);
        iq_send(63, -64); iq_send(64, -65);
        set_fixed(8'hFF);
        iq_send(8, -8); iq_send(7, -9); iq_send(0, 1);
        repeat (3) @(negedge clk);
        check(exp_i_q.size() == 0, "R9 drained", exp_i_q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule